// File: doc/BRIEF.md
# Master Byte Staging Buffer

This block is a small byte buffer that sits between a processor-facing data port and an I2C master engine. Software pushes bytes into it through one data address and pops them back through the same address. The engine can fill slots directly with received bytes and then publish how many are valid. It can also read any slot directly to fetch bytes for transmission. The buffer keeps a fill level and drives two status flags, not-empty and full, for the controller's status register.

A pop always returns the oldest byte from slot 0 and moves every other valid byte down one slot. The head is therefore always at a fixed location. A pop from an empty buffer returns all ones and leaves the buffer unchanged. A push into a full buffer is dropped. A flush input returns the buffer to its reset contents. Depth and byte width are parameters.

Top module: `mdb_buffer`

## Requirements
- R1: After reset the level is 0, both flags are low, every slot reads 0 on the engine read port, and `cpu_rd_data` is all ones.
- R2: A CPU push stores `cpu_wr_data` into the slot numbered by the current level and raises the level by one. A push while the level equals DEPTH is dropped and changes no slot, level or flag.
- R3: A push that raises the level from 0 to 1 sets `not_empty`. A push that raises the level to DEPTH sets `full`.
- R4: While the level is 0, `cpu_rd_data` is all ones, and a pop strobe changes no slot, level or flag.
- R5: While the level is above 0, `cpu_rd_data` shows slot 0. A pop copies slot i+1 into slot i for every i below level-1, lowers the level by one, and leaves slots at or above the new level unchanged.
- R6: A pop taken at level DEPTH clears `full`. A pop taken at level 1 clears `not_empty`.
- R7: `flush` sets the level to 0, zeroes every slot and clears both flags. It overrides every other input in that cycle.
- R8: `eng_wr_en` writes `eng_wr_data` into slot `eng_wr_slot`. `eng_commit` sets the level to `eng_count`, saturated at DEPTH. A commit sets `not_empty` when the count is at least 1 and sets `full` when the count equals DEPTH. A commit never clears either flag.
- R9: A pop and a push in the same cycle are applied pop first. At level DEPTH both take effect and the level stays DEPTH. At level 0 the push lands in slot 0 and the level becomes 1.
- R10: In any cycle with `flush`, `eng_wr_en` or `eng_commit` high, the CPU push and pop strobes are ignored.
- R11: `eng_rd_data` shows the contents of slot `eng_rd_slot` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer and zero all slots |
| cpu_wr_en | input | 1 | CPU push strobe |
| cpu_wr_data | input | DATA_W | Byte to push |
| cpu_rd_en | input | 1 | CPU pop strobe |
| cpu_rd_data | output | DATA_W | Head byte, or all ones when empty |
| eng_wr_en | input | 1 | Engine direct slot write |
| eng_wr_slot | input | IDX_W | Slot written by the engine |
| eng_wr_data | input | DATA_W | Byte written by the engine |
| eng_commit | input | 1 | Engine publishes the valid byte count |
| eng_count | input | CNT_W | Count published by the engine |
| eng_rd_slot | input | IDX_W | Slot selected for the engine read |
| eng_rd_data | output | DATA_W | Contents of the selected slot |
| level | output | CNT_W | Number of valid bytes, 0 to DEPTH |
| not_empty | output | 1 | Not-empty status flag |
| full | output | 1 | Full status flag |

## Verification
The bench aims at the level boundaries. A push at full that overwrites a slot would show a changed byte on the engine read port. A pop at empty that moves the level would show up as wrapped level values. A combined pop and push at full and at empty tests the pop-first ordering: a push-first design would drop the byte at full, or return it immediately at empty. Commits of zero or short counts after the flags were set confirm that a commit never clears a flag. CPU strobes issued alongside engine activity or flush confirm that those strobes are dropped. A long pseudo-random mix of operations compares every slot against the reference model on every cycle, which catches shifts that disturb stale slots above the level.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
   typedef enum logic [1:0] {
      SRC_IDLE   = 2'd0,
      SRC_FLUSH  = 2'd1,
      SRC_ENGINE = 2'd2,
      SRC_CPU    = 2'd3
   } mdb_src_e;
endpackage

// File: rtl/mdb_ctrl.sv
module mdb_ctrl
   import mdb_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             eng_wr_en,
   input  logic             eng_commit,
   input  logic [CNT_W-1:0] eng_count,
   input  logic             cpu_wr_en,
   input  logic             cpu_rd_en,
   output logic [CNT_W-1:0] level,
   output logic             not_empty,
   output logic             full,
   output logic             rd_do,
   output logic             wr_do,
   output logic [IDX_W-1:0] wr_slot
);
   localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);

   mdb_src_e         src;
   logic [CNT_W-1:0] lvl_mid, lvl_n, commit_lvl;
   logic             ne_mid, full_mid, ne_n, full_n;

   always_comb begin
      if (flush)                        src = SRC_FLUSH;
      else if (eng_wr_en || eng_commit) src = SRC_ENGINE;
      else if (cpu_wr_en || cpu_rd_en)  src = SRC_CPU;
      else                              src = SRC_IDLE;
   end

   assign rd_do    = (src == SRC_CPU) && cpu_rd_en && (level != '0);
   assign lvl_mid  = level - CNT_W'(rd_do);
   assign wr_do    = (src == SRC_CPU) && cpu_wr_en && (lvl_mid != LVL_MAX);
   assign wr_slot  = lvl_mid[IDX_W-1:0];
   assign commit_lvl = (eng_count > LVL_MAX) ? LVL_MAX : eng_count;

   // pop applied first, push second
   assign ne_mid   = (rd_do && level == CNT_W'(1)) ? 1'b0 : not_empty;
   assign full_mid = (rd_do && level == LVL_MAX)   ? 1'b0 : full;

   always_comb begin
      lvl_n  = level;
      ne_n   = not_empty;
      full_n = full;
      case (src)
         SRC_FLUSH: begin
            lvl_n  = '0;
            ne_n   = 1'b0;
            full_n = 1'b0;
         end
         SRC_ENGINE: begin
            if (eng_commit) begin
               lvl_n  = commit_lvl;
               ne_n   = not_empty | (commit_lvl != '0);
               full_n = full | (commit_lvl == LVL_MAX);
            end
         end
         SRC_CPU: begin
            lvl_n  = lvl_mid + CNT_W'(wr_do);
            ne_n   = ne_mid | (wr_do && lvl_mid == '0);
            full_n = full_mid | (wr_do && lvl_mid == LVL_MAX - CNT_W'(1));
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level     <= '0;
         not_empty <= 1'b0;
         full      <= 1'b0;
      end else begin
         level     <= lvl_n;
         not_empty <= ne_n;
         full      <= full_n;
      end
   end

   // R2: push at full leaves the level at full
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_CPU && cpu_wr_en && !cpu_rd_en && level == LVL_MAX) |=> (level == LVL_MAX));
   // R4: pop at empty leaves the level alone
   a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_CPU && cpu_rd_en && !cpu_wr_en && level == '0) |=> $stable(level));
   // R3: first push raises not_empty
   a_r3_ne_set: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_CPU && cpu_wr_en && !cpu_rd_en && level == '0) |=> not_empty);
   // R6: pop at full drops the full flag
   a_r6_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_CPU && cpu_rd_en && !cpu_wr_en && level == LVL_MAX) |=> !full);
   // R7: flush empties and clears flags
   a_r7_flush_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0 && !not_empty && !full));
endmodule

// File: rtl/mdb_store.sv
module mdb_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              shift,
   input  logic [CNT_W-1:0]  level,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_slot,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] head
);
   logic [DEPTH*DATA_W-1:0] slot_flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] q, above, nxt;
      if (i < DEPTH - 1) begin : g_up
         assign above = slot_flat[(i+1)*DATA_W +: DATA_W];
      end else begin : g_top
         assign above = q;
      end
      always_comb begin
         nxt = q;
         if (shift && (CNT_W'(i + 1) < level)) nxt = above;
         if (wr_en && (wr_slot == IDX_W'(i)))  nxt = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= '0;
         else if (flush) q <= '0;
         else            q <= nxt;
      end
      assign slot_flat[i*DATA_W +: DATA_W] = q;
   end

   assign rd_data = slot_flat[rd_slot*DATA_W +: DATA_W];
   assign head    = slot_flat[DATA_W-1:0];

   // R7: every slot is zero after a flush
   a_r7_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (slot_flat == '0));
endmodule

// File: rtl/mdb_buffer.sv
module mdb_buffer #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              cpu_wr_en,
   input  logic [DATA_W-1:0] cpu_wr_data,
   input  logic              cpu_rd_en,
   output logic [DATA_W-1:0] cpu_rd_data,
   input  logic              eng_wr_en,
   input  logic [IDX_W-1:0]  eng_wr_slot,
   input  logic [DATA_W-1:0] eng_wr_data,
   input  logic              eng_commit,
   input  logic [CNT_W-1:0]  eng_count,
   input  logic [IDX_W-1:0]  eng_rd_slot,
   output logic [DATA_W-1:0] eng_rd_data,
   output logic [CNT_W-1:0]  level,
   output logic              not_empty,
   output logic              full
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mdb_buffer: DEPTH must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("mdb_buffer: DATA_W must be at least 1");
   end

   logic              rd_do, wr_do, st_wr_en;
   logic [IDX_W-1:0]  cpu_slot, st_wr_slot;
   logic [DATA_W-1:0] st_wr_data, head;

   mdb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .eng_wr_en  (eng_wr_en),
      .eng_commit (eng_commit),
      .eng_count  (eng_count),
      .cpu_wr_en  (cpu_wr_en),
      .cpu_rd_en  (cpu_rd_en),
      .level      (level),
      .not_empty  (not_empty),
      .full       (full),
      .rd_do      (rd_do),
      .wr_do      (wr_do),
      .wr_slot    (cpu_slot)
   );

   assign st_wr_en   = eng_wr_en | wr_do;
   assign st_wr_slot = eng_wr_en ? eng_wr_slot : cpu_slot;
   assign st_wr_data = eng_wr_en ? eng_wr_data : cpu_wr_data;

   mdb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .shift   (rd_do),
      .level   (level),
      .wr_en   (st_wr_en),
      .wr_slot (st_wr_slot),
      .wr_data (st_wr_data),
      .rd_slot (eng_rd_slot),
      .rd_data (eng_rd_data),
      .head    (head)
   );

   assign cpu_rd_data = (level == '0) ? '1 : head;
endmodule

// File: tb/mdb_buffer_tb_top.sv
`timescale 1ns/100ps
module mdb_buffer_tb_top;
   localparam int DW = 8;
   localparam int DEP = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flush = 0, cpu_wr_en = 0, cpu_rd_en = 0, eng_wr_en = 0, eng_commit = 0;
   logic [7:0] cpu_wr_data = 0, eng_wr_data = 0;
   logic [1:0] eng_wr_slot = 0, eng_rd_slot = 0;
   logic [2:0] eng_count = 0;
   logic [7:0] cpu_rd_data, eng_rd_data;
   logic [2:0] level;
   logic       not_empty, full;

   int checks = 0, errors = 0;
   int m_slot[DEP];
   int m_cnt = 0;
   bit m_ne = 0, m_full = 0;
   string req = "R1";

   always #2 clk = ~clk;

   mdb_buffer #(.DATA_W(DW), .DEPTH(DEP)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
      .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
      .eng_wr_en(eng_wr_en), .eng_wr_slot(eng_wr_slot), .eng_wr_data(eng_wr_data),
      .eng_commit(eng_commit), .eng_count(eng_count),
      .eng_rd_slot(eng_rd_slot), .eng_rd_data(eng_rd_data),
      .level(level), .not_empty(not_empty), .full(full)
   );

   task automatic check(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_state();
      check("level", int'(level), m_cnt);
      check("not_empty", int'(not_empty), int'(m_ne));
      check("full", int'(full), int'(m_full));
      check("cpu_rd_data", int'(cpu_rd_data), (m_cnt == 0) ? 8'hFF : m_slot[0]); // R4 R5
      for (int k = 0; k < DEP; k++) begin
         eng_rd_slot = 2'(k);
         #0.1;
         check("slot via eng_rd_data (R11)", int'(eng_rd_data), m_slot[k]);
      end
   endtask

   // behavioural model of one clock edge, from the requirements
   task automatic model_step();
      if (flush) begin
         m_cnt = 0; m_ne = 0; m_full = 0;
         for (int k = 0; k < DEP; k++) m_slot[k] = 0;
      end else if (eng_wr_en || eng_commit) begin
         if (eng_wr_en) m_slot[eng_wr_slot] = eng_wr_data;
         if (eng_commit) begin
            m_cnt = (eng_count > DEP) ? DEP : int'(eng_count);
            if (m_cnt >= 1) m_ne = 1;
            if (m_cnt == DEP) m_full = 1;
         end
      end else begin
         if (cpu_rd_en && m_cnt > 0) begin
            if (m_cnt == DEP) m_full = 0;
            if (m_cnt == 1) m_ne = 0;
            for (int k = 0; k < m_cnt - 1; k++) m_slot[k] = m_slot[k+1];
            m_cnt--;
         end
         if (cpu_wr_en && m_cnt < DEP) begin
            m_slot[m_cnt] = cpu_wr_data;
            m_cnt++;
            if (m_cnt == 1) m_ne = 1;
            if (m_cnt == DEP) m_full = 1;
         end
      end
   endtask

   task automatic cyc(bit f, bit we, int wd, bit re, bit ewe, int es, int ed, bit ec, int ecnt);
      flush = f; cpu_wr_en = we; cpu_wr_data = 8'(wd); cpu_rd_en = re;
      eng_wr_en = ewe; eng_wr_slot = 2'(es); eng_wr_data = 8'(ed);
      eng_commit = ec; eng_count = 3'(ecnt);
      #0.1;
      check("head before edge", int'(cpu_rd_data), (m_cnt == 0) ? 8'hFF : m_slot[0]);
      @(posedge clk);
      model_step();
      @(negedge clk);
      flush = 0; cpu_wr_en = 0; cpu_rd_en = 0; eng_wr_en = 0; eng_commit = 0;
      check_state();
   endtask

   task automatic push(int d);             cyc(0, 1, d, 0, 0, 0, 0, 0, 0); endtask
   task automatic pop();                   cyc(0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
   task automatic pushpop(int d);          cyc(0, 1, d, 1, 0, 0, 0, 0, 0); endtask
   task automatic ewrite(int s, int d);    cyc(0, 0, 0, 0, 1, s, d, 0, 0); endtask
   task automatic ecommit(int n);          cyc(0, 0, 0, 0, 0, 0, 0, 1, n); endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit [15:0] lf;
      for (int k = 0; k < DEP; k++) m_slot[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      req = "R1";
      check_state();

      req = "R2";
      push(8'h11); push(8'h22); push(8'h33);
      req = "R3";
      push(8'h44);
      req = "R2";
      push(8'h55);                         // dropped at full
      req = "R6";
      pop();                               // clears full
      req = "R5";
      pop(); pop();
      req = "R6";
      pop();                               // clears not_empty
      req = "R4";
      pop(); pop();

      req = "R9";
      push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
      pushpop(8'hA5);                      // at full: both act
      pop(); pop(); pop(); pop();
      pushpop(8'hB7);                      // at empty: lands in slot 0
      pop();

      req = "R7";
      push(1); push(2);
      cyc(1, 1, 8'hCC, 1, 1, 2, 8'hDD, 1, 3);

      req = "R8";
      ewrite(0, 8'h5A); ewrite(1, 8'h6B); ewrite(2, 8'h7C);
      ecommit(3);
      cyc(0, 0, 0, 0, 1, 3, 8'h8D, 1, 4);
      ecommit(0);                          // flags stay set
      ecommit(7);                          // saturates
      req = "R10";
      cyc(0, 1, 8'hEE, 1, 1, 1, 8'h99, 0, 0);
      cyc(0, 1, 8'hEF, 1, 0, 0, 0, 1, 2);
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);

      req = "R5";
      lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         case (lf[2:0])
            3'd0, 3'd1: push(int'(lf[15:8]));
            3'd2, 3'd3: pop();
            3'd4:       pushpop(int'(lf[15:8]));
            3'd5:       ewrite(int'(lf[9:8]), int'(lf[15:8]));
            3'd6:       ecommit(int'(lf[10:8]) % 5);
            default:    if (lf[11]) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0); else pop();
         endcase
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule